// File: doc/BRIEF.md
# Repeated-Subtraction Byte Divider

This block divides one unsigned byte by another. It does not use a shift-and-subtract schedule. Instead it counts how many times the divisor can be taken away from a running value. A one-cycle `start_i` pulse captures the dividend and divisor. From then on, each clock cycle increments a quotient counter and subtracts the divisor from the running value.

The loop stops on the first subtraction that borrows, so it always goes one step too far. A single correction cycle then undoes that step: it takes one off the count and adds the divisor back. The result is the quotient and the remainder.

Because of this, the latency grows with the size of the quotient. A zero divisor never enters the loop. It completes at once with an error flag, a saturated quotient and the dividend returned as the remainder.

The divisor is captured at start, so the operand inputs may change while the divider is working. The result outputs hold their values from one completion to the next.

Top module: `rsd_divider`

## Requirements
- R1: While `rst_ni` is low and after its release, `busy_o`, `done_o` and `err_o` are 0, and `quot_o` and `rem_o` are 0.
- R2: For a nonzero divisor d and dividend n, the completion presents `quot_o` = floor(n/d) and `rem_o` = n mod d (for example 95/10 gives 9 and 5).
- R3: For a nonzero divisor, `done_o` is high in the cycle that follows the (q+2)-th rising edge after the edge that sampled `start_i`, where q is the quotient: q+1 subtract cycles plus one correction cycle.
- R4: `done_o` is high for exactly one cycle per accepted start.
- R5: `busy_o` is high in every cycle from the sampling edge of an accepted nonzero-divisor start until completion. It is low in the cycle where `done_o` is high.
- R6: A start with divisor 0 completes on the sampling edge itself (`done_o` high in the next cycle). It gives `quot_o` = all ones, `rem_o` = the dividend and `err_o` = 1, and `busy_o` never rises.
- R7: Every completion with a nonzero divisor clears `err_o` to 0.
- R8: `start_i` is ignored while `busy_o` is high. Operand values offered with such a pulse change neither the result nor the latency of the division in progress.
- R9: `quot_o`, `rem_o` and `err_o` change only on the edge that raises `done_o`. They hold their values during a following division until it completes.
- R10: Boundary cases stay correct. A dividend below the divisor gives quotient 0 in 2 cycles. 255/1 gives quotient 255 in 257 cycles, with the internal count briefly reaching 256 without wrapping.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, sampled when idle |
| num_i | input | WIDTH | Dividend |
| den_i | input | WIDTH | Divisor |
| busy_o | output | 1 | Division in progress |
| done_o | output | 1 | One-cycle completion pulse |
| quot_o | output | WIDTH | Quotient |
| rem_o | output | WIDTH | Remainder |
| err_o | output | 1 | Last completion had a zero divisor |

## Verification
Counting from the edge that samples `start_i`, `done_o` is due after q+2 further edges for a nonzero divisor and after zero further edges for a zero divisor. The results and `err_o` are due in that same cycle, and `done_o` must fall one edge later. The bench drives inputs on falling edges or just after a rising edge and samples 1 ns after each rising edge. It counts edges until `done_o` appears and compares that count with q+2 computed from its own integer division. Across the same window it checks that `busy_o` stayed high and that the previous results did not move.

// File: rtl/rsd_pkg.sv
package rsd_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIX  = 2'd2
  } rsd_state_e;
endpackage

// File: rtl/rsd_subtractor.sv
module rsd_subtractor #(
  parameter int WIDTH  = 8,
  parameter bit RIPPLE = 1'b1
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] diff_o,
  output logic             borrow_o
);
  generate
    if (RIPPLE) begin : g_ripple
      logic [WIDTH:0] bw;
      assign bw[0] = 1'b0;
      for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        assign diff_o[i]  = a_i[i] ^ b_i[i] ^ bw[i];
        assign bw[i+1]    = (~a_i[i] & b_i[i]) | (~(a_i[i] ^ b_i[i]) & bw[i]);
      end
      assign borrow_o = bw[WIDTH];
    end else begin : g_behav
      logic [WIDTH:0] full;
      assign full     = {1'b0, a_i} - {1'b0, b_i};
      assign diff_o   = full[WIDTH-1:0];
      assign borrow_o = full[WIDTH];
    end
  endgenerate
endmodule

// File: rtl/rsd_ctrl.sv
module rsd_ctrl
  import rsd_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic den_zero_i,
  input  logic borrow_i,
  output logic load_o,
  output logic zero_fin_o,
  output logic step_o,
  output logic fix_o,
  output logic busy_o,
  output logic done_o
);
  rsd_state_e state_q, state_d;
  logic       accept;

  assign accept     = start_i && (state_q == ST_IDLE);
  assign load_o     = accept && !den_zero_i;
  assign zero_fin_o = accept && den_zero_i;
  assign step_o     = (state_q == ST_RUN);
  assign fix_o      = (state_q == ST_FIX);
  assign busy_o     = (state_q != ST_IDLE);

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: if (load_o) state_d = ST_RUN;
      ST_RUN:  if (borrow_i) state_d = ST_FIX;  // first borrow ends the loop
      ST_FIX:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      done_o  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_o  <= fix_o || zero_fin_o;
    end
  end

  p_done_pulse_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_idle_at_done_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  p_zero_den_fast_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o && den_zero_i) |=> (done_o && !busy_o));

  p_busy_ends_in_done_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);
endmodule

// File: rtl/rsd_datapath.sv
module rsd_datapath #(
  parameter int WIDTH      = 8,
  parameter bit RIPPLE_SUB = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] num_i,
  input  logic [WIDTH-1:0] den_i,
  input  logic             load_i,
  input  logic             zero_fin_i,
  input  logic             step_i,
  input  logic             fix_i,
  output logic             den_zero_o,
  output logic             borrow_o,
  output logic [WIDTH-1:0] quot_o,
  output logic [WIDTH-1:0] rem_o,
  output logic             err_o
);
  localparam int CW = WIDTH + 1;  // count may reach 2**WIDTH before correction
  localparam logic [CW-1:0] CNT_ONE = CW'(1);

  logic [WIDTH-1:0] den_q, work_q, diff, restored;
  logic [CW-1:0]    cnt_q, cnt_m1;
  logic             borrow;
  logic             past_ok_q;

  rsd_subtractor #(.WIDTH(WIDTH), .RIPPLE(RIPPLE_SUB)) u_sub (
    .a_i     (work_q),
    .b_i     (den_q),
    .diff_o  (diff),
    .borrow_o(borrow)
  );

  assign den_zero_o = (den_i == '0);
  assign borrow_o   = borrow;
  assign restored   = work_q + den_q;  // undo the over-subtraction
  assign cnt_m1     = cnt_q - CNT_ONE;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      den_q  <= '0;
      work_q <= '0;
      cnt_q  <= '0;
    end else if (load_i) begin
      den_q  <= den_i;
      work_q <= num_i;
      cnt_q  <= '0;
    end else if (step_i) begin
      work_q <= diff;
      cnt_q  <= cnt_q + CNT_ONE;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      quot_o <= '0;
      rem_o  <= '0;
      err_o  <= 1'b0;
    end else if (fix_i) begin
      quot_o <= cnt_m1[WIDTH-1:0];
      rem_o  <= restored;
      err_o  <= 1'b0;
    end else if (zero_fin_i) begin
      quot_o <= '1;
      rem_o  <= num_i;
      err_o  <= 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok_q <= 1'b0;
    else         past_ok_q <= 1'b1;
  end

  p_quot_fits_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fix_i |-> !cnt_m1[WIDTH]);

  p_rem_below_den_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fix_i |-> (restored < den_q));

  p_out_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok_q && !$past(fix_i) && !$past(zero_fin_i))
      |-> ($stable(quot_o) && $stable(rem_o) && $stable(err_o)));

  p_zero_err_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    zero_fin_i |=> (err_o && (quot_o == '1)));

  p_err_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fix_i |=> !err_o);
endmodule

// File: rtl/rsd_divider.sv
module rsd_divider #(
  parameter int WIDTH      = 8,
  parameter bit RIPPLE_SUB = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [WIDTH-1:0] num_i,
  input  logic [WIDTH-1:0] den_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [WIDTH-1:0] quot_o,
  output logic [WIDTH-1:0] rem_o,
  output logic             err_o
);
  logic load, zero_fin, step, fix, den_zero, borrow;

  rsd_ctrl u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .den_zero_i(den_zero),
    .borrow_i  (borrow),
    .load_o    (load),
    .zero_fin_o(zero_fin),
    .step_o    (step),
    .fix_o     (fix),
    .busy_o    (busy_o),
    .done_o    (done_o)
  );

  rsd_datapath #(.WIDTH(WIDTH), .RIPPLE_SUB(RIPPLE_SUB)) u_dp (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .num_i     (num_i),
    .den_i     (den_i),
    .load_i    (load),
    .zero_fin_i(zero_fin),
    .step_i    (step),
    .fix_i     (fix),
    .den_zero_o(den_zero),
    .borrow_o  (borrow),
    .quot_o    (quot_o),
    .rem_o     (rem_o),
    .err_o     (err_o)
  );

  p_no_done_while_busy_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !done_o);
endmodule

// File: tb/sim_rsd_divider.sv
module sim_rsd_divider;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       start_i = 1'b0;
  logic [7:0] num_i = '0;
  logic [7:0] den_i = '0;
  logic       busy_o, done_o, err_o;
  logic [7:0] quot_o, rem_o;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #5 clk_i = ~clk_i;

  rsd_divider u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .num_i(num_i),
    .den_i(den_i), .busy_o(busy_o), .done_o(done_o), .quot_o(quot_o),
    .rem_o(rem_o), .err_o(err_o)
  );

  function automatic int exp_q(int n, int d);
    return (d == 0) ? 255 : n / d;
  endfunction
  function automatic int exp_r(int n, int d);
    return (d == 0) ? n : n % d;
  endfunction
  function automatic int exp_lat(int n, int d);
    return (d == 0) ? 0 : n / d + 2;
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic run_div(int n, int d, bit inject);
    int lat = 0;
    int pq, pr, pe;
    bit busy_ok = 1'b1;
    bit hold_ok = 1'b1;
    @(negedge clk_i);
    pq = int'(quot_o); pr = int'(rem_o); pe = int'(err_o);
    start_i = 1'b1; num_i = 8'(n); den_i = 8'(d);
    @(posedge clk_i); #1;
    start_i = 1'b0; num_i = 8'($urandom); den_i = 8'($urandom);
    while (!done_o && lat < 1000) begin
      if (!busy_o) busy_ok = 1'b0;
      if (int'(quot_o) != pq || int'(rem_o) != pr || int'(err_o) != pe) hold_ok = 1'b0;
      if (inject && lat == 3) begin
        start_i = 1'b1; num_i = 8'd9; den_i = 8'd0;
      end else if (inject && lat == 5) begin
        start_i = 1'b1; num_i = 8'd50; den_i = 8'd5;
      end else begin
        start_i = 1'b0;
      end
      @(posedge clk_i); #1;
      lat++;
    end
    start_i = 1'b0;
    if (lat >= 1000) begin
      errors++; checks++;
      $display("FAIL R3 watchdog: no done for %0d/%0d actual=%0d expected=%0d", n, d, lat, exp_lat(n, d));
      return;
    end
    chk(d == 0 ? "R6" : "R2", "quotient", int'(quot_o), exp_q(n, d));
    chk(d == 0 ? "R6" : "R2", "remainder", int'(rem_o), exp_r(n, d));
    chk(d == 0 ? "R6" : "R7", "err flag", int'(err_o), (d == 0) ? 1 : 0);
    chk(d == 0 ? "R6" : "R3", "latency", lat, exp_lat(n, d));
    chk("R5", "busy during run", int'(busy_ok), 1);
    chk("R5", "busy at done", int'(busy_o), 0);
    chk("R9", "results held while running", int'(hold_ok), 1);
    if (inject) begin
      chk("R8", "quotient after ignored starts", int'(quot_o), exp_q(n, d));
      chk("R8", "latency after ignored starts", lat, exp_lat(n, d));
    end
    @(posedge clk_i); #1;
    chk("R4", "done one cycle", int'(done_o), 0);
    chk("R9", "quotient held after done", int'(quot_o), exp_q(n, d));
    chk("R9", "remainder held after done", int'(rem_o), exp_r(n, d));
  endtask

  initial begin
    #1_900_000;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: run did not finish actual=0 expected=1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20241));
    #23;
    chk("R1", "busy in reset", int'(busy_o), 0);
    chk("R1", "done in reset", int'(done_o), 0);
    @(negedge clk_i); rst_ni = 1'b1;
    @(posedge clk_i); #1;
    chk("R1", "quot after reset", int'(quot_o), 0);
    chk("R1", "rem after reset", int'(rem_o), 0);
    chk("R1", "err after reset", int'(err_o), 0);
    chk("R1", "busy after reset", int'(busy_o), 0);

    run_div(95, 10, 1'b0);   // R2 worked example
    run_div(0, 0, 1'b0);     // R6
    run_div(128, 0, 1'b0);   // R6
    run_div(77, 7, 1'b0);    // R7 clears err after zero-divisor run
    run_div(3, 7, 1'b0);     // R10 dividend below divisor
    run_div(254, 255, 1'b0); // R10
    run_div(0, 5, 1'b0);     // R10
    run_div(255, 255, 1'b0);
    run_div(255, 1, 1'b0);   // R10 count reaches 256 internally
    run_div(200, 7, 1'b1);   // R8 starts while busy ignored
    run_div(100, 1, 1'b1);   // R8

    for (int i = 0; i < 60; i++) begin
      int n, d;
      n = int'($urandom_range(0, 255));
      if ($urandom_range(0, 11) == 0) d = 0;
      else if ($urandom_range(0, 3) == 0) d = int'($urandom_range(1, 4));
      else d = int'($urandom_range(1, 255));
      run_div(n, d, 1'b0);
    end

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule